// File: doc/BRIEF.md
# Serial Control Register Slave for a TV Sound Processor

This block sits on a two-wire serial control bus (I2C) and holds the setting registers of a TV sound processor: separation trim, tone, volume, balance, output routing and mute bits. A host writes the device address byte 0x84, then a register pointer, then any number of data bytes. The pointer steps by one after every data byte, so the whole setting bank can be loaded in one transfer. The host reads through address byte 0x85 and gets a status byte with a power-on flag and the two broadcast-mode detector flags.

SCL and SDA are sampled in a faster system clock through a synchronizer. The block never drives SDA high: it only pulls the line low, for acknowledge bits and for zero bits of read data, and it changes SDA only while the synchronized SCL is low. The decoded fields appear as parallel outputs. After reset both sound outputs are muted and the volume is at its minimum, so nothing is heard until the host has set up the device.

Top module: `sndCtlI2cSlave`

## Requirements
- R1: After reset, the fields are: testMode=0, attLevel=0x34, extSel=0, forceMono=0, outSel1=0, outSel0=0, tvUnmute=0, lsUnmute=0 (both outputs muted), bassLvl=0x10, trebleLvl=0x10, volLvl=0x00, balLvl=0x20. sdaDrvLow is 0.
- R2: The address byte 0x84 (write) and the address byte 0x85 (read) are acknowledged. Any other address byte is not acknowledged, and the bytes that follow it, up to the next START, change no field and are not acknowledged.
- R3: Only the low 4 bits of the register-pointer byte are used. The upper 4 bits are ignored.
- R4: Each data byte of a write goes to the current pointer. The pointer then increments by one and wraps from 15 to 0, so one transfer can load consecutive registers.
- R5: The fields sit at these register positions:
  - pointer 0: testMode = bit 7, attLevel = bits 6:0
  - pointer 1: extSel = bit 5, forceMono = bit 0
  - pointer 2: bassLvl = bits 4:0
  - pointer 3: trebleLvl = bits 4:0
  - pointer 4: outSel1 = bit 7, outSel0 = bit 6, tvUnmute = bit 5, lsUnmute = bit 4
  - pointer 5: volLvl = bits 7:0
  - pointer 6: balLvl = bits 5:0
  
  A field changes only in response to a data byte written to its own register.
- R6: Data bytes written to pointers 7 to 15 are acknowledged and change no field.
- R7: A read returns the status byte MSB first: bit 7 is the power-on flag, bit 6 is stereoDet, bit 5 is bilingDet, and bits 4:0 are 0. The power-on flag is 1 after reset.
- R8: The power-on flag clears once a status byte has been sent, so later reads show bit 7 = 0.
- R9: When the host ACKs a read byte, a fresh status byte follows. When the host NACKs, the read ends and SDA stays released until the next START.
- R10: SDA is released in the cycle after a detected START or STOP, and it stays released while the bus is idle.
- R11: sdaDrvLow changes only while the synchronized SCL is low, except for the release that follows a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| stereoDet | input | 1 | Stereo broadcast detected |
| bilingDet | input | 1 | Bilingual broadcast detected |
| sdaDrvLow | output | 1 | 1 pulls SDA low (open-drain enable) |
| testMode | output | 1 | Test mode select |
| attLevel | output | 7 | Stereo separation input-level trim |
| extSel | output | 1 | Speaker path takes the external input |
| forceMono | output | 1 | Forced mono |
| outSel1 | output | 1 | Output routing select, upper bit |
| outSel0 | output | 1 | Output routing select, lower bit |
| tvUnmute | output | 1 | TV output enabled (0 = muted) |
| lsUnmute | output | 1 | Speaker output enabled (0 = muted) |
| bassLvl | output | 5 | Bass setting |
| trebleLvl | output | 5 | Treble setting |
| volLvl | output | 8 | Volume setting |
| balLvl | output | 6 | Balance setting |

## Verification
Four rules are checked on every clock:
- SDA is released right after any START or STOP.
- SDA moves only while the synchronized SCL is low.
- A field changes only after a data-write strobe from the bus controller.
- The power-on flag falls only after a status byte has been issued.

Only the bench scenarios can show the byte-level results:
- which address bytes get an ACK;
- how the pointer increments and wraps;
- where each field sits in its register;
- that reserved registers are ignored;
- the bit order of the status byte;
- that a NACK ends a read.

// File: rtl/sndctl_pkg.sv
package sndctl_pkg;

  localparam int ATT_W  = 7;
  localparam int TONE_W = 5;
  localparam int VOL_W  = 8;
  localparam int BAL_W  = 6;
  localparam int PTR_W  = 4;

  // strobes from the bus controller to the register datapath
  typedef struct packed {
    logic ptrLoad;   // rxByte holds a register pointer
    logic dataWr;    // rxByte holds data for the current pointer
    logic statusRd;  // a status byte was just issued to the bus
  } busStb_t;

  typedef enum logic [2:0] {
    BUS_IDLE,
    BUS_ADDR,
    BUS_PTR,
    BUS_WDATA,
    BUS_TX,
    BUS_MACK,
    BUS_RELOAD
  } busState_t;

endpackage

// File: rtl/sndCtlSync.sv
module sndCtlSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/sndCtlBusCtrl.sv
module sndCtlBusCtrl
  import sndctl_pkg::*;
#(
  parameter logic [7:0] WR_ADDR = 8'h84
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclSync,
  input  logic       sdaSync,
  input  logic [7:0] statusByte,
  output busStb_t    strobe,
  output logic [7:0] rxByte,
  output logic       sdaLow,
  output logic       startDet,
  output logic       stopDet
);
  localparam logic [7:0] RD_ADDR = WR_ADDR | 8'h01;

  busState_t  state;
  logic       sclPrev, sdaPrev;
  logic [3:0] bitCnt;
  logic [7:0] shiftReg;
  logic       ackPend, inAck, isRead;
  logic       sclRise, sclFall;
  logic [7:0] rxNext;

  assign sclRise  = sclSync & ~sclPrev;
  assign sclFall  = ~sclSync & sclPrev;
  assign startDet = sclSync & sclPrev & sdaPrev & ~sdaSync;
  assign stopDet  = sclSync & sclPrev & ~sdaPrev & sdaSync;
  assign rxNext   = {shiftReg[6:0], sdaSync};
  assign rxByte   = shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclSync;
      sdaPrev <= sdaSync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= BUS_IDLE;
      bitCnt   <= '0;
      shiftReg <= '0;
      ackPend  <= 1'b0;
      inAck    <= 1'b0;
      isRead   <= 1'b0;
      sdaLow   <= 1'b0;
      strobe   <= '0;
    end else begin
      strobe <= '0;
      if (startDet) begin
        state   <= BUS_ADDR;
        bitCnt  <= '0;
        sdaLow  <= 1'b0;
        ackPend <= 1'b0;
        inAck   <= 1'b0;
      end else if (stopDet) begin
        state   <= BUS_IDLE;
        sdaLow  <= 1'b0;
        ackPend <= 1'b0;
        inAck   <= 1'b0;
      end else begin
        unique case (state)
          BUS_IDLE: ;
          BUS_ADDR, BUS_PTR, BUS_WDATA: begin
            if (inAck) begin
              if (sclFall) begin
                inAck  <= 1'b0;
                sdaLow <= 1'b0;
                bitCnt <= '0;
                if (state == BUS_ADDR && isRead) begin
                  shiftReg        <= statusByte;
                  sdaLow          <= ~statusByte[7];
                  strobe.statusRd <= 1'b1;
                  state           <= BUS_TX;
                end else if (state == BUS_ADDR) begin
                  state <= BUS_PTR;
                end else begin
                  state <= BUS_WDATA;
                end
              end
            end else if (ackPend) begin
              if (sclFall) begin
                ackPend <= 1'b0;
                inAck   <= 1'b1;
                sdaLow  <= 1'b1;
              end
            end else if (sclRise) begin
              shiftReg <= rxNext;
              bitCnt   <= bitCnt + 4'd1;
              if (bitCnt == 4'd7) begin
                if (state == BUS_ADDR) begin
                  if (rxNext == WR_ADDR) begin
                    isRead  <= 1'b0;
                    ackPend <= 1'b1;
                  end else if (rxNext == RD_ADDR) begin
                    isRead  <= 1'b1;
                    ackPend <= 1'b1;
                  end else begin
                    state <= BUS_IDLE;
                  end
                end else if (state == BUS_PTR) begin
                  strobe.ptrLoad <= 1'b1;
                  ackPend        <= 1'b1;
                end else begin
                  strobe.dataWr <= 1'b1;
                  ackPend       <= 1'b1;
                end
              end
            end
          end
          BUS_TX: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall) begin
              if (bitCnt == 4'd8) begin
                sdaLow <= 1'b0;
                state  <= BUS_MACK;
              end else begin
                shiftReg <= {shiftReg[6:0], 1'b0};
                sdaLow   <= ~shiftReg[6];
              end
            end
          end
          BUS_MACK: begin
            if (sclRise) state <= sdaSync ? BUS_IDLE : BUS_RELOAD;
          end
          BUS_RELOAD: begin
            if (sclFall) begin
              shiftReg        <= statusByte;
              sdaLow          <= ~statusByte[7];
              strobe.statusRd <= 1'b1;
              bitCnt          <= '0;
              state           <= BUS_TX;
            end
          end
          default: state <= BUS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sndCtlRegFile.sv
module sndCtlRegFile
  import sndctl_pkg::*;
#(
  parameter logic [ATT_W-1:0]  ATT_INIT  = 7'h34,
  parameter logic [TONE_W-1:0] TONE_INIT = 5'h10,
  parameter logic [BAL_W-1:0]  BAL_INIT  = 6'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStb_t           strobe,
  input  logic [7:0]        rxByte,
  input  logic              stereoDet,
  input  logic              bilingDet,
  output logic [7:0]        statusByte,
  output logic              testMode,
  output logic [ATT_W-1:0]  attLevel,
  output logic              extSel,
  output logic              forceMono,
  output logic              outSel1,
  output logic              outSel0,
  output logic              tvUnmute,
  output logic              lsUnmute,
  output logic [TONE_W-1:0] bassLvl,
  output logic [TONE_W-1:0] trebleLvl,
  output logic [VOL_W-1:0]  volLvl,
  output logic [BAL_W-1:0]  balLvl
);
  localparam logic [PTR_W-1:0] PTR_TRIM  = PTR_W'(0);
  localparam logic [PTR_W-1:0] PTR_INSEL = PTR_W'(1);
  localparam logic [PTR_W-1:0] PTR_BASS  = PTR_W'(2);
  localparam logic [PTR_W-1:0] PTR_TREB  = PTR_W'(3);
  localparam logic [PTR_W-1:0] PTR_ROUTE = PTR_W'(4);
  localparam logic [PTR_W-1:0] PTR_VOL   = PTR_W'(5);
  localparam logic [PTR_W-1:0] PTR_BAL   = PTR_W'(6);

  logic [PTR_W-1:0] regPtr;
  logic             ponFlag;

  assign statusByte = {ponFlag, stereoDet, bilingDet, 5'b0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regPtr  <= '0;
      ponFlag <= 1'b1;
    end else begin
      if (strobe.statusRd) ponFlag <= 1'b0;
      if (strobe.ptrLoad)     regPtr <= rxByte[PTR_W-1:0];
      else if (strobe.dataWr) regPtr <= regPtr + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      testMode  <= 1'b0;
      attLevel  <= ATT_INIT;
      extSel    <= 1'b0;
      forceMono <= 1'b0;
      outSel1   <= 1'b0;
      outSel0   <= 1'b0;
      tvUnmute  <= 1'b0;
      lsUnmute  <= 1'b0;
      bassLvl   <= TONE_INIT;
      trebleLvl <= TONE_INIT;
      volLvl    <= '0;
      balLvl    <= BAL_INIT;
    end else if (strobe.dataWr) begin
      case (regPtr)
        PTR_TRIM: begin
          testMode <= rxByte[7];
          attLevel <= rxByte[ATT_W-1:0];
        end
        PTR_INSEL: begin
          extSel    <= rxByte[5];
          forceMono <= rxByte[0];
        end
        PTR_BASS: bassLvl   <= rxByte[TONE_W-1:0];
        PTR_TREB: trebleLvl <= rxByte[TONE_W-1:0];
        PTR_ROUTE: begin
          outSel1  <= rxByte[7];
          outSel0  <= rxByte[6];
          tvUnmute <= rxByte[5];
          lsUnmute <= rxByte[4];
        end
        PTR_VOL: volLvl <= rxByte[VOL_W-1:0];
        PTR_BAL: balLvl <= rxByte[BAL_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sndCtlI2cSlave.sv
module sndCtlI2cSlave
  import sndctl_pkg::*;
#(
  parameter logic [7:0] WR_ADDR     = 8'h84,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              stereoDet,
  input  logic              bilingDet,
  output logic              sdaDrvLow,
  output logic              testMode,
  output logic [ATT_W-1:0]  attLevel,
  output logic              extSel,
  output logic              forceMono,
  output logic              outSel1,
  output logic              outSel0,
  output logic              tvUnmute,
  output logic              lsUnmute,
  output logic [TONE_W-1:0] bassLvl,
  output logic [TONE_W-1:0] trebleLvl,
  output logic [VOL_W-1:0]  volLvl,
  output logic [BAL_W-1:0]  balLvl
);
  logic       sclSync, sdaSync;
  logic       startDet, stopDet;
  busStb_t    strobe;
  logic [7:0] rxByte;
  logic [7:0] statusByte;

  sndCtlSync #(.STAGES(SYNC_STAGES)) u_sclSync (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclSync));
  sndCtlSync #(.STAGES(SYNC_STAGES)) u_sdaSync (
    .clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaSync));

  sndCtlBusCtrl #(.WR_ADDR(WR_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclSync(sclSync), .sdaSync(sdaSync),
    .statusByte(statusByte), .strobe(strobe), .rxByte(rxByte),
    .sdaLow(sdaDrvLow), .startDet(startDet), .stopDet(stopDet));

  sndCtlRegFile u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxByte(rxByte),
    .stereoDet(stereoDet), .bilingDet(bilingDet), .statusByte(statusByte),
    .testMode(testMode), .attLevel(attLevel), .extSel(extSel),
    .forceMono(forceMono), .outSel1(outSel1), .outSel0(outSel0),
    .tvUnmute(tvUnmute), .lsUnmute(lsUnmute), .bassLvl(bassLvl),
    .trebleLvl(trebleLvl), .volLvl(volLvl), .balLvl(balLvl));
endmodule

// File: rtl/sndCtlI2cChecker.sv
module sndCtlI2cChecker (
  input logic       clk,
  input logic       rstN,
  input logic       sclSync,
  input logic       startDet,
  input logic       stopDet,
  input logic       sdaDrvLow,
  input logic       dataWr,
  input logic       statusRd,
  input logic       ponFlag,
  input logic [7:0] volLvl,
  input logic       tvUnmute,
  input logic       lsUnmute
);
  // R1: while reset is held, both outputs are muted and volume is at minimum
  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_muted_r1: assert (!tvUnmute && !lsUnmute && volLvl == 8'h00)
        else $error("R1 reset values not held");
    end
  end

  // R10: release SDA after START
  p_start_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaDrvLow);

  // R10: release SDA after STOP
  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaDrvLow);

  // R11: SDA moves only while the synchronized SCL is low
  p_sda_scl_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaDrvLow) && !$past(startDet) && !$past(stopDet)) |-> !$past(sclSync));

  // R5: a field changes only after a data-write strobe
  p_field_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (volLvl != $past(volLvl)) |-> $past(dataWr));

  // R8: the power-on flag falls only after a status byte was issued
  p_pon_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ponFlag) |-> $past(statusRd));
endmodule

bind sndCtlI2cSlave sndCtlI2cChecker u_chk (
  .clk(clk), .rstN(rstN), .sclSync(sclSync), .startDet(startDet),
  .stopDet(stopDet), .sdaDrvLow(sdaDrvLow), .dataWr(strobe.dataWr),
  .statusRd(strobe.statusRd), .ponFlag(statusByte[7]), .volLvl(volLvl),
  .tvUnmute(tvUnmute), .lsUnmute(lsUnmute));

// File: tb/sim_sndCtlI2cSlave.sv
`timescale 1ns/1ps
module sim_sndCtlI2cSlave;
  localparam int QUARTER = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic stereoDet = 1'b0;
  logic bilingDet = 1'b0;
  logic sdaDrvLow;
  logic sdaBus;
  logic testMode, extSel, forceMono, outSel1, outSel0, tvUnmute, lsUnmute;
  logic [6:0] attLevel;
  logic [4:0] bassLvl, trebleLvl;
  logic [7:0] volLvl;
  logic [5:0] balLvl;

  int checks = 0;
  int fails  = 0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] obsQ[$];
  event       obsEv;

  always #10 clk = ~clk;
  assign sdaBus = sdaM & ~sdaDrvLow;

  sndCtlI2cSlave u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .stereoDet(stereoDet), .bilingDet(bilingDet), .sdaDrvLow(sdaDrvLow),
    .testMode(testMode), .attLevel(attLevel), .extSel(extSel),
    .forceMono(forceMono), .outSel1(outSel1), .outSel0(outSel0),
    .tvUnmute(tvUnmute), .lsUnmute(lsUnmute), .bassLvl(bassLvl),
    .trebleLvl(trebleLvl), .volLvl(volLvl), .balLvl(balLvl));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ(input int n = 1);
    repeat (n * QUARTER) @(negedge clk);
  endtask

  task automatic i2cStart();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic i2cStop();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ(2);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitQ();
      sclM = 1'b1; waitQ(2);
      sclM = 1'b0; waitQ();
    end
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    acked = (sdaBus == 1'b0);
    waitQ();
    sclM = 1'b0; waitQ();
  endtask

  // reads one byte, hands it to the monitor, then answers ACK (0) or NACK (1)
  task automatic readByte(input logic nack);
    logic [7:0] got;
    got = '0;
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ();
      sclM = 1'b1; waitQ();
      got[i] = sdaBus;
      waitQ();
      sclM = 1'b0;
    end
    waitQ();
    sdaM = nack; waitQ();
    sclM = 1'b1; waitQ(2);
    sclM = 1'b0; waitQ();
    sdaM = 1'b1;
    obsQ.push_back(got);
    ->obsEv;
  endtask

  task automatic expectByte(input string tag, input logic [7:0] v);
    expQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  // monitor: pairs observed read bytes with expected ones
  initial begin
    forever begin
      @(obsEv);
      while (obsQ.size() > 0) begin
        logic [7:0] o;
        o = obsQ.pop_front();
        if (expQ.size() == 0) begin
          check("R7 unexpected read byte", o, 32'hFFFF_FFFF);
        end else begin
          check(tagQ.pop_front(), o, expQ.pop_front());
        end
      end
    end
  end

  task automatic writeRegs(input string tag, input logic [7:0] bytes[$]);
    logic ack;
    i2cStart();
    sendByte(8'h84, ack);
    check({tag, " R2 write address ACK"}, ack, 1);
    foreach (bytes[k]) begin
      sendByte(bytes[k], ack);
      check({tag, " byte ACK"}, ack, 1);
    end
    i2cStop();
  endtask

  task automatic checkFields(input string tag,
    input logic t, input logic [6:0] a, input logic e, input logic f,
    input logic s1, input logic s0, input logic tv, input logic ls,
    input logic [4:0] b, input logic [4:0] tr, input logic [7:0] v, input logic [5:0] bl);
    check({tag, " testMode"},  testMode,  t);
    check({tag, " attLevel"},  attLevel,  a);
    check({tag, " extSel"},    extSel,    e);
    check({tag, " forceMono"}, forceMono, f);
    check({tag, " outSel1"},   outSel1,   s1);
    check({tag, " outSel0"},   outSel0,   s0);
    check({tag, " tvUnmute"},  tvUnmute,  tv);
    check({tag, " lsUnmute"},  lsUnmute,  ls);
    check({tag, " bassLvl"},   bassLvl,   b);
    check({tag, " trebleLvl"}, trebleLvl, tr);
    check({tag, " volLvl"},    volLvl,    v);
    check({tag, " balLvl"},    balLvl,    bl);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic ack;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    checkFields("R1 reset", 0, 7'h34, 0, 0, 0, 0, 0, 0, 5'h10, 5'h10, 8'h00, 6'h20);
    check("R1 sdaDrvLow idle", sdaDrvLow, 0);

    // R7 first read: PON=1, stereo=1
    stereoDet = 1'b1;
    i2cStart();
    sendByte(8'h85, ack);
    check("R2 read address ACK", ack, 1);
    expectByte("R7 status after reset", 8'hC0);
    readByte(1'b1);
    waitQ(3);
    check("R9 SDA released after NACK", sdaDrvLow, 0);
    i2cStop();
    check("R10 SDA released after STOP", sdaDrvLow, 0);

    // R8 second read: PON cleared
    i2cStart();
    sendByte(8'h85, ack);
    expectByte("R8 status PON cleared", 8'h40);
    readByte(1'b1);
    i2cStop();

    // R9 ACKed read gives a second byte, NACK ends it
    stereoDet = 1'b0;
    bilingDet = 1'b1;
    i2cStart();
    sendByte(8'h85, ack);
    expectByte("R9 first status byte", 8'h20);
    readByte(1'b0);
    expectByte("R9 second status byte", 8'h20);
    readByte(1'b1);
    waitQ(4);
    check("R9 SDA stays released before STOP", sdaDrvLow, 0);
    i2cStop();

    // R4 R5 burst from pointer 0 through 6
    writeRegs("R4", '{8'h00, 8'h85, 8'h21, 8'h1F, 8'h03, 8'hF0, 8'h80, 8'h3F});
    checkFields("R5 burst", 1, 7'h05, 1, 1, 1, 1, 1, 1, 5'h1F, 5'h03, 8'h80, 6'h3F);

    // R3 upper pointer nibble ignored: 0xA5 selects volume
    writeRegs("R3", '{8'hA5, 8'h11});
    check("R3 volLvl via 0xA5", volLvl, 8'h11);

    // R6 reserved pointers 7 and 8
    writeRegs("R6", '{8'h07, 8'hFF, 8'hFF});
    checkFields("R6 unchanged", 1, 7'h05, 1, 1, 1, 1, 1, 1, 5'h1F, 5'h03, 8'h11, 6'h3F);

    // R4 wrap from 15 to 0
    writeRegs("R4 wrap", '{8'h0F, 8'hAA, 8'h12});
    checkFields("R4 wrap", 0, 7'h12, 1, 1, 1, 1, 1, 1, 5'h1F, 5'h03, 8'h11, 6'h3F);

    // R2 foreign address ignored
    i2cStart();
    sendByte(8'h90, ack);
    check("R2 foreign address NACK", ack, 0);
    sendByte(8'h05, ack);
    check("R2 following byte NACK", ack, 0);
    sendByte(8'h00, ack);
    check("R2 second following byte NACK", ack, 0);
    i2cStop();
    checkFields("R2 unchanged", 0, 7'h12, 1, 1, 1, 1, 1, 1, 5'h1F, 5'h03, 8'h11, 6'h3F);

    // R5 routing register alone: S0 only, both muted again
    writeRegs("R5 route", '{8'h04, 8'h40});
    checkFields("R5 route", 0, 7'h12, 1, 1, 0, 1, 0, 0, 5'h1F, 5'h03, 8'h11, 6'h3F);

    // R7 status reflects both detectors after writes
    stereoDet = 1'b1;
    i2cStart();
    sendByte(8'h85, ack);
    expectByte("R7 status both flags", 8'h60);
    readByte(1'b1);
    i2cStop();
    check("R10 idle release", sdaDrvLow, 0);

    waitQ(2);
    check("R7 all expected bytes seen", expQ.size(), 0);
    finishRun();
  end
endmodule